// File: doc/BRIEF.md
# Prefetch Engine Control and Status Slice

This block is the register-facing half of a read-prefetch / write-posting engine. Software programs a direction and a FIFO threshold in one configuration register and a transfer count in another, then writes the control register to start the engine. The start write preloads the FIFO fill counter: it is set to full for write posting (the buffer is free for the host to fill) and to empty for read prefetch. While the engine runs, the neighbouring datapath reports FIFO pushes, FIFO pops and completed bus transfers. The block keeps the fill level, the remaining transfer count and the run bit. When the last transfer completes it raises a completion event.

A single status word packs the fill level, a flag showing that the fill level is above the programmed threshold, and the remaining count. An interrupt status/enable pair gates the completion event onto a level interrupt. Push and pop acknowledge strobes show which requests the fill counter accepted, so a datapath or testbench can follow the FIFO without reading registers.

Top module: `pf_engine_csr`

## Requirements
- R1: After synchronous reset the registers read as follows: configuration A reads 0x00004000, and configuration B, control, status, interrupt status and interrupt enable all read 0. Both acknowledge strobes and `irq` are low.
- R2: Configuration A (word address 0) keeps only the bits of 0x7F8F7FBF on write. Its bit 0 is the direction (1 = write posting) and bits 14:8 are the threshold. Configuration B (address 1) keeps only bits 13:0, the transfer count.
- R3: The word address map is 0 cfg A, 1 cfg B, 2 control, 3 status, 4 interrupt status and 5 interrupt enable. A read at address N returns, on `reg_rdata` one cycle later, the state held before that edge. Addresses 6 and 7 read 0, and writes to them change nothing.
- R4: A control write with bit 0 = 1 does three things. It loads the fill level with 64 if cfg A bit 0 is 1, or with 0 otherwise. It loads the remaining count from cfg B. It sets the run bit only if that count is nonzero. A control write with bit 0 = 0 clears the run bit and keeps the fill level and the remaining count. Control bit 0 reads back the run bit.
- R5: A push is accepted only while the engine runs and the fill level is below 64. A pop is accepted only while the engine runs and the fill level is above 0. Nothing is accepted in a cycle that writes control. The fill level moves by the net number of accepted requests. `push_ack` and `pop_ack` pulse in the cycle after an accepted request.
- R6: Status bit 16 is 1 exactly when the fill level is strictly greater than cfg A bits 14:8.
- R7: Status reads as fill level in bits 30:24, the threshold flag in bit 16 and the remaining count in bits 13:0, with every other bit 0. Writes to status are ignored.
- R8: `beat_done` while running decrements the remaining count. The decrement that reaches zero also clears the run bit and sets interrupt status bit 1. `beat_done` has no effect when the engine is stopped or in a cycle that writes control.
- R9: Interrupt enable keeps only bits 0xF03. Writing 1 to an interrupt status bit clears it. A completion event in the same cycle as the clear wins.
- R10: `irq` equals the OR of (interrupt status AND interrupt enable) and changes on the same edge as those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| push_req | input | 1 | Datapath asks to add one FIFO entry |
| pop_req | input | 1 | Datapath asks to remove one FIFO entry |
| beat_done | input | 1 | One bus transfer finished |
| push_ack | output | 1 | Previous cycle's push was accepted |
| pop_ack | output | 1 | Previous cycle's pop was accepted |
| irq | output | 1 | Level interrupt |

## Verification
A fill counter that is off by one shows up in the first rejected push at 64 or the first rejected pop at 0. It also shows up on the acknowledge strobes one cycle after the bad request, well before any status read. A wrong remaining count or run bit appears as a completion interrupt that comes one beat early or late. The reference model therefore compares `irq` and both strobes on every clock, and compares every read result on the cycle it returns. Random traffic drives the counters through the saturation points and through start and stop writes that land in the middle of a transfer.

// File: rtl/pf_csr_pkg.sv
package pf_csr_pkg;
  localparam int DATA_W = 32;
  localparam int IRQ_W  = 12;

  localparam logic [2:0] ADR_CFGA  = 3'd0;
  localparam logic [2:0] ADR_CFGB  = 3'd1;
  localparam logic [2:0] ADR_CTRL  = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_ISTAT = 3'd4;
  localparam logic [2:0] ADR_IEN   = 3'd5;

  localparam logic [DATA_W-1:0] CFGA_KEEP  = 32'h7F8F_7FBF;
  localparam logic [DATA_W-1:0] CFGA_INIT  = 32'h0000_4000;
  localparam logic [IRQ_W-1:0]  IEN_KEEP   = 12'hF03;
  localparam logic [IRQ_W-1:0]  IST_SOURCES = 12'h002;

  localparam int DONE_BIT   = 1;
  localparam int DIR_BIT    = 0;
  localparam int THR_LSB    = 8;
  localparam int THR_W      = 7;
  localparam int FILL_LSB   = 24;
  localparam int FLAG_BIT   = 16;
endpackage

// File: rtl/pf_fill_tracker.sv
module pf_fill_tracker #(
  parameter int DEPTH = 64,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             load_en,
  input  logic             load_full,
  input  logic             run,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [OCC_W-1:0] occ,
  output logic             push_ack,
  output logic             pop_ack
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic push_ok, pop_ok;

  assign push_ok = run && !hold && push_req && (occ != FULL);
  assign pop_ok  = run && !hold && pop_req  && (occ != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ      <= '0;
      push_ack <= 1'b0;
      pop_ack  <= 1'b0;
    end else begin
      push_ack <= push_ok;
      pop_ack  <= pop_ok;
      if (load_en)
        occ <= load_full ? FULL : '0;
      else
        occ <= occ + OCC_W'(push_ok) - OCC_W'(pop_ok);
    end
  end

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL) else $error("fill level above depth"); // R5

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ((int'(occ) <= int'($past(occ)) + 1) &&
                  (int'(occ) + 1 >= int'($past(occ)))))
    else $error("fill level jumped"); // R5

  AST_ACK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (!run || hold) |=> (!push_ack && !pop_ack))
    else $error("ack while stopped"); // R5
endmodule

// File: rtl/pf_xfer_counter.sv
module pf_xfer_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             ctrl_go,
  input  logic [CNT_W-1:0] load_val,
  input  logic             beat,
  output logic [CNT_W-1:0] remaining,
  output logic             running,
  output logic             finish
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign finish = running && !ctrl_wr && beat && (remaining == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      running   <= 1'b0;
    end else if (ctrl_wr) begin
      if (ctrl_go) begin
        remaining <= load_val;
        running   <= |load_val;
      end else begin
        running   <= 1'b0;
      end
    end else if (running && beat) begin
      remaining <= remaining - ONE;
      if (remaining == ONE)
        running <= 1'b0;
    end
  end

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    running |-> (remaining != '0)) else $error("running with zero count"); // R8

  AST_FINISH_STOPS: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!running && remaining == '0)) else $error("finish did not stop"); // R8

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!running && !ctrl_wr) |=> $stable(remaining)) else $error("count moved while idle"); // R8
endmodule

// File: rtl/pf_irq_unit.sv
module pf_irq_unit #(
  parameter int              W       = 12,
  parameter logic [W-1:0]    EN_KEEP = 12'hF03,
  parameter logic [W-1:0]    SOURCES = 12'h002
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_wr,
  input  logic         st_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt_set,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         irq
);
  logic [W-1:0] st_next, en_next;

  assign en_next = en_wr ? (wdata & EN_KEEP) : enable;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (SOURCES[b]) begin : g_src
      assign st_next[b] = evt_set[b] || (status[b] && !(st_wr && wdata[b]));
      always_ff @(posedge clk) begin
        if (rst) status[b] <= 1'b0;
        else     status[b] <= st_next[b];
      end
    end else begin : g_none
      assign st_next[b] = 1'b0;
      assign status[b]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      enable <= en_next;
      irq    <= |(st_next & en_next);
    end
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & enable)) else $error("irq out of step"); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    |(evt_set & SOURCES) |=> |(status & $past(evt_set))) else $error("event lost"); // R9
endmodule

// File: rtl/pf_engine_csr.sv
module pf_engine_csr #(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              beat_done,
  output logic              push_ack,
  output logic              pop_ack,
  output logic              irq
);
  import pf_csr_pkg::*;

  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [31:0] CNT_KEEP = 32'((64'd1 << CNT_W) - 1);

  logic [31:0]       cfg_a, cfg_b;
  logic [OCC_W-1:0]  occ;
  logic [CNT_W-1:0]  remaining;
  logic              running, finish, over_thr;
  logic [IRQ_W-1:0]  ist, ien;
  logic [31:0]       stat_word, rd_mux;
  logic [THR_W-1:0]  thr;

  logic wr_cfga, wr_cfgb, wr_ctrl, wr_ist, wr_ien;
  assign wr_cfga = reg_wr && (3'(reg_addr) == ADR_CFGA);
  assign wr_cfgb = reg_wr && (3'(reg_addr) == ADR_CFGB);
  assign wr_ctrl = reg_wr && (3'(reg_addr) == ADR_CTRL);
  assign wr_ist  = reg_wr && (3'(reg_addr) == ADR_ISTAT);
  assign wr_ien  = reg_wr && (3'(reg_addr) == ADR_IEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a <= CFGA_INIT;
      cfg_b <= '0;
    end else begin
      if (wr_cfga) cfg_a <= reg_wdata & CFGA_KEEP;
      if (wr_cfgb) cfg_b <= reg_wdata & CNT_KEEP;
    end
  end

  pf_fill_tracker #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .hold      (wr_ctrl),
    .load_en   (wr_ctrl && reg_wdata[0]),
    .load_full (cfg_a[DIR_BIT]),
    .run       (running),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .occ       (occ),
    .push_ack  (push_ack),
    .pop_ack   (pop_ack)
  );

  pf_xfer_counter #(.CNT_W(CNT_W)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wr_ctrl),
    .ctrl_go   (reg_wdata[0]),
    .load_val  (cfg_b[CNT_W-1:0]),
    .beat      (beat_done),
    .remaining (remaining),
    .running   (running),
    .finish    (finish)
  );

  pf_irq_unit #(.W(IRQ_W), .EN_KEEP(IEN_KEEP), .SOURCES(IST_SOURCES)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .en_wr   (wr_ien),
    .st_wr   (wr_ist),
    .wdata   (reg_wdata[IRQ_W-1:0]),
    .evt_set (IRQ_W'(finish) << DONE_BIT),
    .status  (ist),
    .enable  (ien),
    .irq     (irq)
  );

  assign thr       = cfg_a[THR_LSB +: THR_W];
  assign over_thr  = 32'(occ) > 32'(thr);
  assign stat_word = (32'(occ) << FILL_LSB) | (32'(over_thr) << FLAG_BIT) | 32'(remaining);

  always_comb begin
    case (3'(reg_addr))
      ADR_CFGA:  rd_mux = cfg_a;
      ADR_CFGB:  rd_mux = cfg_b;
      ADR_CTRL:  rd_mux = 32'(running);
      ADR_STAT:  rd_mux = stat_word;
      ADR_ISTAT: rd_mux = 32'(ist);
      ADR_IEN:   rd_mux = 32'(ien);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_STAT_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd) && ($past(3'(reg_addr)) == ADR_STAT) |-> (reg_rdata[30:24] <= 7'(DEPTH)))
    else $error("status fill field too large"); // R7
endmodule

// File: tb/test_pf_engine_csr.sv
module test_pf_engine_csr;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic push_req = 0, pop_req = 0, beat_done = 0;
  logic push_ack, pop_ack, irq;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pf_engine_csr i_pf_engine_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_req(push_req),
    .pop_req(pop_req), .beat_done(beat_done), .push_ack(push_ack),
    .pop_ack(pop_ack), .irq(irq));

  // behavioural reference model
  int m_cfga, m_cfgb, m_occ, m_rem, m_ien;
  bit m_run, m_ist, m_irq, m_pack, m_popk, m_rdv;
  int m_rdata;
  string m_rtag;

  function automatic int mread(int a);
    int thr;
    thr = (m_cfga >> 8) & 127;
    case (a)
      0: return m_cfga;
      1: return m_cfgb;
      2: return int'(m_run);
      3: return (m_occ << 24) | (((m_occ > thr) ? 1 : 0) << 16) | m_rem;
      4: return m_ist ? 2 : 0;
      5: return m_ien;
      default: return 0;
    endcase
  endfunction

  function automatic string rtag(int a);
    case (a)
      0, 1: return "R2";
      2: return "R4";
      3: return "R7";
      4, 5: return "R9";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfga = 32'h4000; m_cfgb = 0; m_occ = 0; m_rem = 0; m_ien = 0;
      m_run = 0; m_ist = 0; m_irq = 0; m_pack = 0; m_popk = 0; m_rdv = 0; m_rdata = 0;
    end else begin
      bit cw, fin, pk, pp, clr;
      int a, wd;
      a = int'(reg_addr); wd = reg_wdata;
      m_rdv = reg_rd;
      if (reg_rd) begin m_rdata = mread(a); m_rtag = rtag(a); end
      cw = reg_wr && a == 2;
      pk = m_run && !cw && push_req && m_occ < 64;
      pp = m_run && !cw && pop_req && m_occ > 0;
      fin = 0;
      if (cw) begin
        if (wd[0]) begin
          m_occ = m_cfga[0] ? 64 : 0;
          m_rem = m_cfgb; m_run = (m_cfgb != 0);
        end else m_run = 0;
      end else begin
        m_occ = m_occ + (pk ? 1 : 0) - (pp ? 1 : 0);
        if (m_run && beat_done) begin
          m_rem = m_rem - 1;
          if (m_rem == 0) begin m_run = 0; fin = 1; end
        end
      end
      m_pack = pk; m_popk = pp;
      clr = reg_wr && a == 4 && wd[1];
      m_ist = fin ? 1'b1 : (clr ? 1'b0 : m_ist);
      if (reg_wr && a == 0) m_cfga = wd & 32'h7F8F7FBF;
      if (reg_wr && a == 1) m_cfgb = wd & 32'h3FFF;
      if (reg_wr && a == 5) m_ien = wd & 32'hF03;
      m_irq = m_ist && m_ien[1];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 irq", 32'(irq), 32'(m_irq));
      chk("R5 push_ack", 32'(push_ack), 32'(m_pack));
      chk("R5 pop_ack", 32'(pop_ack), 32'(m_popk));
      if (m_rdv) chk(m_rtag, reg_rdata, m_rdata);
    end
  end

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    reg_rd = 1; reg_addr = 3'(a);
    @(posedge clk); #1;
    reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic hold(bit p, bit q, bit b, int n);
    push_req = p; pop_req = q; beat_done = b;
    repeat (n) @(posedge clk);
    #1;
    push_req = 0; pop_req = 0; beat_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1 reset values
    rd_chk(0, 32'h4000, "R1");
    rd_chk(1, 0, "R1");
    rd_chk(2, 0, "R1");
    rd_chk(3, 0, "R1");
    rd_chk(4, 0, "R1");
    rd_chk(5, 0, "R1");
    chk("R1 irq", 32'(irq), 0);
    // R2 masks
    wr(0, 32'hFFFF_FFFF); rd_chk(0, 32'h7F8F_7FBF, "R2");
    wr(1, 32'hFFFF_FFFF); rd_chk(1, 32'h3FFF, "R2");
    // R3 unmapped
    wr(6, 32'hFFFF_FFFF); rd_chk(6, 0, "R3"); rd_chk(7, 0, "R3");
    // R4 start in write-posting direction, threshold 5, count 3
    wr(0, 32'h0000_0501); wr(1, 3); wr(2, 1);
    rd_chk(2, 1, "R4");
    rd_chk(3, 32'h4001_0003, "R4");
    // R5 pops down to 4, R6 threshold edges
    hold(0, 1, 0, 60); rd_chk(3, 32'h0400_0003, "R6");
    hold(0, 1, 0, 1);  hold(1, 0, 0, 2); rd_chk(3, 32'h0500_0003, "R6");
    hold(1, 0, 0, 1);  rd_chk(3, 32'h0601_0003, "R6");
    // R7 status ignores writes
    wr(3, 32'hFFFF_FFFF); rd_chk(3, 32'h0601_0003, "R7");
    // R9 enable mask, R8 completion
    wr(5, 32'hFFFF); rd_chk(5, 32'hF03, "R9");
    hold(0, 0, 1, 3);
    chk("R10 irq raised", 32'(irq), 1);
    rd_chk(2, 0, "R8");
    rd_chk(3, 32'h0601_0000, "R8");
    rd_chk(4, 2, "R9");
    wr(4, 2);
    chk("R10 irq cleared", 32'(irq), 0);
    rd_chk(4, 0, "R9");
    // R4 stop keeps fill level and count
    wr(0, 1); wr(1, 5); wr(2, 1); wr(2, 0);
    rd_chk(2, 0, "R4");
    rd_chk(3, 32'h4001_0005, "R4");
    // R4 read direction, zero count does not run; R5 push ignored when stopped
    wr(0, 0); wr(1, 0); wr(2, 1);
    rd_chk(2, 0, "R4");
    hold(1, 0, 1, 2);
    rd_chk(3, 0, "R5");
    // random traffic against the model
    for (int i = 0; i < 5000; i++) begin
      int a;
      push_req  = ($urandom % 2) == 0;
      pop_req   = ($urandom % 3) == 0;
      beat_done = ($urandom % 8) == 0;
      reg_rd    = ($urandom % 4) == 0;
      a = int'($urandom % 8);
      reg_addr  = 3'(a);
      reg_wr    = ($urandom % 12) == 0;
      case (a)
        1: reg_wdata = $urandom % 24;
        2: reg_wdata = (($urandom % 4) != 0) ? 1 : 0;
        default: reg_wdata = $urandom;
      endcase
      @(posedge clk); #1;
    end
    reg_wr = 0; reg_rd = 0; push_req = 0; pop_req = 0; beat_done = 0;
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule